// File: doc/BRIEF.md
# Panel Initialization Command Sequencer

This block plays back a list of display-panel commands held in a small byte-wide ROM outside the block. Each entry in the list describes itself. It holds a packet data type, a wait time in milliseconds, a payload byte count, and then that many payload bytes. The sequencer walks the list one record at a time. It streams each payload to a downstream packet framer over a valid/ready handshake. It then holds off for the stated number of milliseconds before it reads the next record.

Two lists live in the ROM: one for power-up and one for power-down. A start pulse picks one of them through a select input. While a list plays, busy is high. A one-cycle done pulse marks the moment the last record's wait has run out. A record that is malformed stops playback and raises an error flag. Malformed means the record runs past the end of its list, or a short-write type carries the wrong byte count.

A millisecond tick comes from a divider sized by a clock-frequency parameter. The divider only runs while a wait is in progress.

Top module: `panel_init_player`

## Requirements
- R1: Each record is read as type byte, delay byte, length byte, then length payload bytes. Every payload byte is sent as one beat on `pkt_byte`. During the beat, `pkt_dtype` carries the type byte and `pkt_wc` carries the length byte, zero-extended to 16 bits.
- R2: `pkt_last` is high on the final payload beat of a record and low on every other beat. While `pkt_valid` is high and `pkt_ready` is low, all packet outputs stay unchanged.
- R3: After the last beat of a record, the first beat of the next record is not accepted until `delay` milliseconds have elapsed. A delay of 0 lets the next record start at once, after only its three header reads.
- R4: One millisecond equals CLK_HZ/1000 clock cycles. The tick divider restarts at the start of every wait, so a wait of N counts N whole periods.
- R5: `sel_down` sampled with `start` picks the list: 0 selects the power-up list and 1 selects the power-down list. Each list is given by a base address and a byte length.
- R6: A `start` pulse while `busy` is high has no effect. The list in progress plays on unchanged.
- R7: `busy` is high from the cycle after an accepted start until playback ends. `done` pulses for exactly one cycle, with `busy` low, once the final record's wait has elapsed.
- R8: Playback aborts with `err` set and no `done` pulse in either of two cases. The first is a record whose three header bytes or whose payload would extend past the end of the list. The second is the case named in R9. `err` stays set until the next accepted start clears it.
- R9: Short-write types must carry a fixed length. Types 0x03 and 0x05 take 1 byte. Types 0x13, 0x15 and 0x07 take 2 bytes. Type 0x23 takes 3 bytes. Any other type, such as 0x29 or 0x0A, is passed through with its given length.
- R10: After reset, `pkt_valid`, `busy`, `done` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin playback of the selected list |
| sel_down | input | 1 | List select: 0 power-up, 1 power-down |
| rom_addr | output | ADDR_W | Command ROM byte address |
| rom_data | input | 8 | Command ROM byte, combinational read of `rom_addr` |
| pkt_valid | output | 1 | Payload beat valid |
| pkt_ready | input | 1 | Downstream accepts the beat |
| pkt_dtype | output | 8 | Packet data type of the current record |
| pkt_wc | output | 16 | Payload byte count of the current record |
| pkt_byte | output | 8 | Payload byte |
| pkt_last | output | 1 | Final payload byte of the record |
| busy | output | 1 | A list is being played |
| done | output | 1 | One-cycle pulse: list finished |
| err | output | 1 | Sticky malformed-record flag |

## Verification
The hardest case to reach from the ports is a millisecond wait that overlaps with downstream back-pressure. Both must hold together: the gap rule between records and the stall rule within a record. The bench therefore plays the power-up list, whose 120 ms wait follows a 2 ms wait, under a pseudo-random ready pattern. It measures the cycle distance from each last beat to the next first beat.

The abort paths are reached by patching length bytes in the bench-owned ROM between runs. This produces both a payload overrun after a good record and a short-type length mismatch on the first record. A clean rerun then shows the error clearing.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HDR_TYPE,
    S_HDR_DELAY,
    S_HDR_LEN,
    S_SEND,
    S_WAIT
  } seq_state_t;

  // Required length for short-write types, 0 when the type is not short.
  function automatic logic [7:0] short_len(input logic [7:0] dt);
    case (dt)
      8'h03, 8'h05:        short_len = 8'd1;
      8'h13, 8'h15, 8'h07: short_len = 8'd2;
      8'h23:               short_len = 8'd3;
      default:             short_len = 8'd0;
    endcase
  endfunction

  function automatic logic len_mismatch(input logic [7:0] dt, input logic [7:0] len);
    logic [7:0] need;
    need = short_len(dt);
    len_mismatch = (need != 8'd0) && (need != len);
  endfunction

  // Bytes remaining between a pointer and the list limit.
  function automatic int unsigned room_left(input int unsigned ptr, input int unsigned lim);
    room_left = (lim > ptr) ? (lim - ptr) : 0;
  endfunction

endpackage

// File: rtl/panel_ms_tick.sv
module panel_ms_tick #(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic tick
);
  localparam int unsigned TICKS = CLK_HZ / 1000;
  localparam int unsigned CW    = (TICKS > 2) ? $clog2(TICKS) : 1;

  logic [CW-1:0] count;

  assign tick = enable && (count == CW'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (!enable) count <= '0;
    else if (tick)    count <= '0;
    else              count <= count + 1'b1;
  end
endmodule

// File: rtl/panel_list_bounds.sv
module panel_list_bounds #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned UP_BASE = 0,
  parameter int unsigned UP_LEN  = 64,
  parameter int unsigned DN_BASE = 128,
  parameter int unsigned DN_LEN  = 64
) (
  input  logic            sel_down,
  output logic [ADDR_W:0] base,
  output logic [ADDR_W:0] limit
);
  localparam logic [ADDR_W:0] UP_LO = (ADDR_W+1)'(UP_BASE);
  localparam logic [ADDR_W:0] UP_HI = (ADDR_W+1)'(UP_BASE + UP_LEN);
  localparam logic [ADDR_W:0] DN_LO = (ADDR_W+1)'(DN_BASE);
  localparam logic [ADDR_W:0] DN_HI = (ADDR_W+1)'(DN_BASE + DN_LEN);

  assign base  = sel_down ? DN_LO : UP_LO;
  assign limit = sel_down ? DN_HI : UP_HI;
endmodule

// File: rtl/panel_seq_core.sv
module panel_seq_core
  import panel_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W:0]   list_base,
  input  logic [ADDR_W:0]   list_limit,
  input  logic              tick,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [7:0]        rom_data,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [7:0]        pkt_dtype,
  output logic [15:0]       pkt_wc,
  output logic [7:0]        pkt_byte,
  output logic              pkt_last,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              wait_active,
  output logic              hdr_fault,
  output logic [ADDR_W:0]   cur_limit
);
  seq_state_t      st;
  logic [ADDR_W:0] ptr, lim;
  logic [7:0]      dtype_q, delay_q, len_q, left_q;
  logic [ADDR_W:0] avail, body_room;
  logic            at_end, hdr_short, body_over, bad_len;

  assign avail     = lim - ptr;
  assign body_room = avail - 1'b1;
  assign at_end    = (ptr == lim);
  assign hdr_short = !at_end && (avail < (ADDR_W+1)'(3));
  assign body_over = ((ADDR_W+1)'(rom_data) > body_room);
  assign bad_len   = len_mismatch(dtype_q, rom_data);

  assign hdr_fault = ((st == S_HDR_TYPE) && hdr_short) ||
                     ((st == S_HDR_LEN) && (body_over || bad_len));

  assign wait_active = (st == S_WAIT) && (delay_q != 8'd0);
  assign cur_limit   = lim;

  assign rom_addr  = ptr[ADDR_W-1:0];
  assign pkt_valid = (st == S_SEND);
  assign pkt_dtype = dtype_q;
  assign pkt_wc    = {8'd0, len_q};
  assign pkt_byte  = rom_data;
  assign pkt_last  = (st == S_SEND) && (left_q == 8'd1);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ptr     <= '0;
      lim     <= '0;
      dtype_q <= '0;
      delay_q <= '0;
      len_q   <= '0;
      left_q  <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            ptr <= list_base;
            lim <= list_limit;
            err <= 1'b0;
            st  <= S_HDR_TYPE;
          end
        end
        S_HDR_TYPE: begin
          if (at_end) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (hdr_fault) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else begin
            dtype_q <= rom_data;
            ptr     <= ptr + 1'b1;
            st      <= S_HDR_DELAY;
          end
        end
        S_HDR_DELAY: begin
          delay_q <= rom_data;
          ptr     <= ptr + 1'b1;
          st      <= S_HDR_LEN;
        end
        S_HDR_LEN: begin
          if (hdr_fault) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else begin
            len_q  <= rom_data;
            left_q <= rom_data;
            ptr    <= ptr + 1'b1;
            st     <= (rom_data == 8'd0) ? S_WAIT : S_SEND;
          end
        end
        S_SEND: begin
          if (pkt_ready) begin
            ptr    <= ptr + 1'b1;
            left_q <= left_q - 1'b1;
            if (left_q == 8'd1) st <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (delay_q == 8'd0)  st      <= S_HDR_TYPE;
          else if (tick)        delay_q <= delay_q - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/panel_init_player.sv
module panel_init_player #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned UP_BASE = 0,
  parameter int unsigned UP_LEN  = 64,
  parameter int unsigned DN_BASE = 128,
  parameter int unsigned DN_LEN  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sel_down,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [7:0]        rom_data,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [7:0]        pkt_dtype,
  output logic [15:0]       pkt_wc,
  output logic [7:0]        pkt_byte,
  output logic              pkt_last,
  output logic              busy,
  output logic              done,
  output logic              err
);
  logic [ADDR_W:0] list_base, list_limit, cur_limit;
  logic            ms_tick, wait_active, hdr_fault, start_taken;

  assign start_taken = start && !busy;

  panel_list_bounds #(
    .ADDR_W(ADDR_W), .UP_BASE(UP_BASE), .UP_LEN(UP_LEN),
    .DN_BASE(DN_BASE), .DN_LEN(DN_LEN)
  ) u_bounds (
    .sel_down(sel_down),
    .base    (list_base),
    .limit   (list_limit)
  );

  panel_ms_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .enable(wait_active),
    .tick  (ms_tick)
  );

  panel_seq_core #(.ADDR_W(ADDR_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_taken),
    .list_base  (list_base),
    .list_limit (list_limit),
    .tick       (ms_tick),
    .rom_addr   (rom_addr),
    .rom_data   (rom_data),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_dtype  (pkt_dtype),
    .pkt_wc     (pkt_wc),
    .pkt_byte   (pkt_byte),
    .pkt_last   (pkt_last),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .wait_active(wait_active),
    .hdr_fault  (hdr_fault),
    .cur_limit  (cur_limit)
  );
endmodule

// File: rtl/panel_init_checker.sv
module panel_init_checker #(
  parameter int unsigned ADDR_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            pkt_valid,
  input logic            pkt_ready,
  input logic [7:0]      pkt_dtype,
  input logic [15:0]     pkt_wc,
  input logic [7:0]      pkt_byte,
  input logic            pkt_last,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic            ms_tick,
  input logic            hdr_fault,
  input logic [ADDR_W:0] cur_limit
);
  assert_hold_on_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_byte) && $stable(pkt_dtype)
                                && $stable(pkt_wc) && $stable(pkt_last));

  assert_valid_needs_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> busy);

  assert_tick_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ms_tick |=> !ms_tick);

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(cur_limit));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !err);

  assert_fault_aborts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fault |=> err && !busy && !done);
endmodule

bind panel_init_player panel_init_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .pkt_valid(pkt_valid),
  .pkt_ready(pkt_ready),
  .pkt_dtype(pkt_dtype),
  .pkt_wc   (pkt_wc),
  .pkt_byte (pkt_byte),
  .pkt_last (pkt_last),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .ms_tick  (ms_tick),
  .hdr_fault(hdr_fault),
  .cur_limit(cur_limit)
);

// File: tb/test_panel_init_player.sv
module test_panel_init_player;
  localparam int ADDR_W = 8;
  localparam int CLK_HZ = 8000;
  localparam int TMS    = CLK_HZ / 1000;
  localparam int UPB = 0,  UPL = 19;
  localparam int DNB = 32, DNL = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sel_down = 1'b0, pkt_ready = 1'b1;
  logic [ADDR_W-1:0] rom_addr;
  logic [7:0] rom_data, pkt_dtype, pkt_byte;
  logic [15:0] pkt_wc;
  logic pkt_valid, pkt_last, busy, done, err;
  logic [7:0] rom [0:255];

  assign rom_data = rom[rom_addr];
  always #5 clk = ~clk;

  panel_init_player #(.ADDR_W(ADDR_W), .CLK_HZ(CLK_HZ), .UP_BASE(UPB), .UP_LEN(UPL),
                      .DN_BASE(DNB), .DN_LEN(DNL)) i_panel_init_player (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_down(sel_down),
    .rom_addr(rom_addr), .rom_data(rom_data), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_dtype(pkt_dtype), .pkt_wc(pkt_wc), .pkt_byte(pkt_byte), .pkt_last(pkt_last),
    .busy(busy), .done(done), .err(err));

  int checks = 0, fails = 0;
  logic [32:0] exp_q[$];
  int dly_q[$];
  bit exp_err;
  bit running = 0, have_prev = 0, finished = 0;
  int rmode = 0, cyc = 0, last_cyc = 0, last_dly = 0, done_cnt = 0;
  logic [7:0] lfsr = 8'h5A;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int need_len(input logic [7:0] t);
    case (t)
      8'h03, 8'h05: return 1;
      8'h13, 8'h15, 8'h07: return 2;
      8'h23: return 3;
      default: return 0;
    endcase
  endfunction

  // Reference parse of a list straight from the requirements.
  task automatic build_expect(input int base, input int len);
    int p, e, n, d;
    logic [7:0] t;
    exp_q.delete(); dly_q.delete(); exp_err = 0;
    p = base; e = base + len;
    while (p < e) begin
      if (e - p < 3) begin exp_err = 1; break; end
      t = rom[p]; d = rom[p+1]; n = rom[p+2]; p += 3;
      if (p + n > e) begin exp_err = 1; break; end
      if (need_len(t) != 0 && need_len(t) != n) begin exp_err = 1; break; end
      for (int i = 0; i < n; i++) exp_q.push_back({t, 8'd0, 8'(n), rom[p+i], (i == n-1)});
      dly_q.push_back(d);
      p += n;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (!running || rmode == 0) pkt_ready = 1'b1;
    else if (rmode == 1) pkt_ready = lfsr[0] | lfsr[2];
    else pkt_ready = (cyc % 3 == 0);
    if (running && pkt_valid && pkt_ready) begin
      logic [32:0] got, want;
      got = {pkt_dtype, pkt_wc, pkt_byte, pkt_last};
      if (exp_q.size() == 0) check(0, "R1", "unexpected beat", longint'(got), 0);
      else begin
        want = exp_q.pop_front();
        check(got == want, "R1", "beat dtype/wc/byte/last", longint'(got), longint'(want));
        if (have_prev) begin
          have_prev = 0;
          check(cyc - last_cyc >= last_dly * TMS + 1, "R3", "gap too short",
                cyc - last_cyc, last_dly * TMS + 1);
          if (rmode == 0)
            check(cyc - last_cyc <= last_dly * TMS + 6, "R4", "gap too long",
                  cyc - last_cyc, last_dly * TMS + 6);
        end
        if (want[0]) begin
          have_prev = 1; last_cyc = cyc;
          last_dly = (dly_q.size() != 0) ? dly_q.pop_front() : 0;
        end
      end
    end
    if (running && done) begin
      done_cnt++;
      check(cyc - last_cyc >= last_dly * TMS + 1 && cyc - last_cyc <= last_dly * TMS + 4,
            "R7", "done timing after final wait", cyc - last_cyc, last_dly * TMS + 3);
      have_prev = 0;
    end
    if (cyc == 150000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_list(input bit dn, input int mode, input bit poke, input string tag);
    build_expect(dn ? DNB : UPB, dn ? DNL : UPL);
    rmode = mode; done_cnt = 0; have_prev = 0; last_dly = 0;
    @(negedge clk); running = 1; start = 1; sel_down = dn;
    @(negedge clk); start = 0;
    check(busy == 1'b1, "R7", {tag, " busy after start"}, busy, 1);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (poke && i == 10) begin start = 1; sel_down = !dn; end
      else start = 0;
      if (!busy && !start) break;
    end
    start = 0;
    repeat (3) @(negedge clk);
    running = 0;
    check(exp_q.size() == 0, "R5", {tag, " beats left unsent"}, exp_q.size(), 0);
    check(done_cnt == (exp_err ? 0 : 1), "R7", {tag, " done pulse count"}, done_cnt, exp_err ? 0 : 1);
    check(err == exp_err, "R8", {tag, " err flag"}, err, exp_err);
    check(busy == 1'b0, "R7", {tag, " idle at end"}, busy, 0);
  endtask

  initial begin
    logic [7:0] init_up [0:18] = '{8'h29, 8'h00, 8'h03, 8'hB0, 8'h11, 8'h22,
                                   8'h15, 8'h02, 8'h02, 8'h36, 8'h00,
                                   8'h05, 8'h78, 8'h01, 8'h11,
                                   8'h05, 8'h00, 8'h01, 8'h29};
    logic [7:0] init_dn [0:7] = '{8'h05, 8'h00, 8'h01, 8'h28, 8'h05, 8'h01, 8'h01, 8'h10};
    for (int i = 0; i < 256; i++) rom[i] = 8'hEE;
    for (int i = 0; i < 19; i++) rom[UPB + i] = init_up[i];
    for (int i = 0; i < 8; i++) rom[DNB + i] = init_dn[i];

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!pkt_valid, "R10", "reset valid", pkt_valid, 0);
    check(!busy, "R10", "reset busy", busy, 0);
    check(!done, "R10", "reset done", done, 0);
    check(!err, "R10", "reset err", err, 0);

    run_list(0, 0, 0, "R5 power-up, always ready");
    run_list(1, 0, 0, "R5 power-down, always ready");
    run_list(0, 1, 0, "R2 power-up, random stalls");
    run_list(1, 2, 0, "R2 power-down, sparse ready");
    run_list(0, 0, 1, "R6 start poked while busy");

    rom[DNB + 6] = 8'h05;                     // R8: payload overruns list end
    run_list(1, 0, 0, "R8 overrun");
    rom[DNB + 6] = 8'h01;
    rom[DNB + 2] = 8'h02;                     // R9: type 0x05 with length 2
    run_list(1, 1, 0, "R9 short length mismatch");
    rom[DNB + 2] = 8'h01;
    run_list(1, 0, 0, "R8 err cleared by new start");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule